// File: doc/BRIEF.md
# Cascaded Modulo-193 Counter with Pause

An eight-bit synchronous counter assembled from two four-bit counting slices that share one clock. The lower slice's carry-out is the count qualifier of the upper slice, so the upper nibble advances only on the cycle the lower nibble rolls over. Once the whole value reaches 255, a preset returns it to 63. This closes a loop of 193 distinct states, which makes the block usable as a divide-by-193 stage.

A global enable freezes the count at any value. The preset is qualified by that enable, so the counter can also rest at 255 without leaving it. An active-low synchronous clear drives the value to 0. Zero lies below the loop, so after a clear the counter climbs through 0..62 and then enters the loop at 63. A terminal flag marks the cycle on which the wrap from 255 to 63 will take place.

Top module: `mod193_counter`

## Requirements
- R1: While `clearN` is 0 at a rising clock edge, `countOut` is 0 after that edge, whatever `enable` is.
- R2: With `clearN` 1, `enable` 1 and `countOut` not 255, `countOut` becomes `countOut + 1` at the next edge.
- R3: With `clearN` 1, `enable` 1 and `countOut` equal to 255, `countOut` becomes 63 (binary 0011_1111) at the next edge.
- R4: Once `countOut` is 63 or more, it never drops below 63 unless a clear occurs. Across enabled cycles it returns to any loop value after exactly 193 enabled cycles.
- R5: With `clearN` 1 and `enable` 0, `countOut` keeps its value at the next edge, including when the value is 255.
- R6: `tcOut` is 1 exactly when `countOut` is 255 and `enable` is 1.
- R7: After a clear, enabled counting passes through every value 0..62 in order and reaches 63 after 63 enabled cycles.
- R8: The upper nibble changes only on an enabled edge at which the lower nibble is 15. For example, 0x4F goes to 0x50, and a paused 0x4F stays 0x4F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for both slices |
| clearN | input | 1 | Active-low synchronous clear to 0 |
| enable | input | 1 | Count enable; 0 holds the value, including at 255 |
| countOut | output | 8 | Present count value |
| tcOut | output | 1 | Terminal flag: count is 255 and enable is 1 |

## Verification
A directed walk from a clear runs through the entry region 0..62 and one full loop. It separates a correct entry path and a correct 193-cycle period from an off-by-one preset or a wrong wrap point. Pauses at 255, at an arbitrary middle value and at a nibble boundary show whether the preset is qualified by the enable and whether the upper slice moves only on the lower carry. A long stretch of seeded random enable patterns, with occasional clears, measures the enabled-cycle distance between successive wraps. This exposes any skipped or doubled state that only appears when pauses land at random points.

// File: rtl/mod193_pkg.sv
package mod193_pkg;
  typedef struct packed {
    logic clearNow;  // force all slices to zero
    logic loadAll;   // whole-counter preset
    logic countEn;   // parallel count enable to every slice
  } ctrlStrobes_t;
endpackage

// File: rtl/mod193_slice.sv
module mod193_slice #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clearNow,
  input  logic         loadNow,
  input  logic         enP,
  input  logic         enT,
  input  logic [W-1:0] loadVal,
  output logic [W-1:0] q,
  output logic         carry
);
  // priority: clear, then load, then count
  always_ff @(posedge clk) begin
    if (clearNow)          q <= '0;
    else if (loadNow)      q <= loadVal;
    else if (enP && enT)   q <= q + 1'b1;
  end

  assign carry = enT && (&q);
endmodule

// File: rtl/mod193_datapath.sv
module mod193_datapath
  import mod193_pkg::*;
#(
  parameter int SLICE_W = 4,
  parameter int SLICES  = 2,
  parameter int CNT_W   = SLICE_W * SLICES,
  parameter logic [CNT_W-1:0] PRESET_V = '0
) (
  input  logic             clk,
  input  ctrlStrobes_t     strb,
  output logic [CNT_W-1:0] countOut,
  output logic             chainCarry
);
  logic [SLICES:0] tChain;
  assign tChain[0] = strb.countEn;

  for (genvar i = 0; i < SLICES; i++) begin : gSlice
    mod193_slice #(.W(SLICE_W)) slice_i (
      .clk     (clk),
      .clearNow(strb.clearNow),
      .loadNow (strb.loadAll),
      .enP     (strb.countEn),
      .enT     (tChain[i]),
      .loadVal (PRESET_V[i*SLICE_W +: SLICE_W]),
      .q       (countOut[i*SLICE_W +: SLICE_W]),
      .carry   (tChain[i+1])
    );
  end

  assign chainCarry = tChain[SLICES];

  // R1: clear wins over everything
  assert_clear_zero_R1: assert property (@(posedge clk)
    strb.clearNow |=> (countOut == '0));

  // R2: single increment when enabled below the top
  assert_step_R2: assert property (@(posedge clk) disable iff (strb.clearNow)
    (strb.countEn && countOut != '1) |=> (countOut == CNT_W'($past(countOut) + 1'b1)));

  // R3: wrap from all-ones to the preset
  assert_wrap_R3: assert property (@(posedge clk) disable iff (strb.clearNow)
    (strb.countEn && countOut == '1) |=> (countOut == PRESET_V));

  // R4: the loop is closed
  assert_stay_in_loop_R4: assert property (@(posedge clk) disable iff (strb.clearNow)
    (countOut >= PRESET_V) |=> (countOut >= PRESET_V));

  // R5: hold when paused
  assert_hold_R5: assert property (@(posedge clk) disable iff (strb.clearNow)
    (!strb.countEn) |=> $stable(countOut));

  // R8: upper nibble moves only on a lower-slice carry
  assert_upper_on_carry_R8: assert property (@(posedge clk) disable iff (strb.clearNow)
    !(strb.countEn && countOut[SLICE_W-1:0] == '1)
      |=> ($stable(countOut[CNT_W-1:SLICE_W])
           || $past(countOut) == '1));
endmodule

// File: rtl/mod193_ctrl.sv
module mod193_ctrl
  import mod193_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             clearN,
  input  logic             enable,
  input  logic             chainCarry,
  input  logic [CNT_W-1:0] countOut,
  output ctrlStrobes_t     strb,
  output logic             tcOut
);
  always_comb begin
    strb.clearNow = !clearN;
    strb.countEn  = enable;
    // carry chain is already qualified by enable, so a paused 255 never presets
    strb.loadAll  = chainCarry;
  end

  assign tcOut = chainCarry;

  // R6: terminal flag matches the full-count-and-enabled condition
  assert_tc_R6: assert property (@(posedge clk) disable iff (!clearN)
    tcOut == (enable && countOut == '1));

  // R5: no preset while paused
  assert_no_load_paused_R5: assert property (@(posedge clk) disable iff (!clearN)
    !enable |-> !strb.loadAll);
endmodule

// File: rtl/mod193_counter.sv
module mod193_counter
  import mod193_pkg::*;
#(
  parameter int SLICE_W = 4,
  parameter int SLICES  = 2,
  parameter int PRESET  = 63
) (
  input  logic                      clk,
  input  logic                      clearN,
  input  logic                      enable,
  output logic [SLICE_W*SLICES-1:0] countOut,
  output logic                      tcOut
);
  localparam int CNT_W = SLICE_W * SLICES;
  localparam logic [CNT_W-1:0] PRESET_V = CNT_W'(PRESET);

  ctrlStrobes_t strb;
  logic chainCarry;

  mod193_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk       (clk),
    .clearN    (clearN),
    .enable    (enable),
    .chainCarry(chainCarry),
    .countOut  (countOut),
    .strb      (strb),
    .tcOut     (tcOut)
  );

  mod193_datapath #(
    .SLICE_W (SLICE_W),
    .SLICES  (SLICES),
    .CNT_W   (CNT_W),
    .PRESET_V(PRESET_V)
  ) dp_i (
    .clk       (clk),
    .strb      (strb),
    .countOut  (countOut),
    .chainCarry(chainCarry)
  );
endmodule

// File: tb/mod193_counter_tb.sv
module mod193_counter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LOOP_LEN   = 193;

  logic       clk = 1'b0;
  logic       clearN = 1'b0;
  logic       enable = 1'b0;
  logic [7:0] countOut;
  logic       tcOut;

  int checks = 0;
  int errors = 0;
  logic [7:0] expCount = 8'd0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mod193_counter dut_i (
    .clk(clk), .clearN(clearN), .enable(enable),
    .countOut(countOut), .tcOut(tcOut)
  );

  function automatic logic [7:0] nextVal(logic [7:0] c, logic en, logic clrN);
    if (!clrN)        return 8'd0;
    if (!en)          return c;
    if (c == 8'd255)  return 8'd63;
    return c + 8'd1;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: inputs set after a negedge, flag checked, count checked next negedge
  task automatic cycle(input logic en, input logic clrN, input string tag);
    enable = en;
    clearN = clrN;
    #1;
    check("R6 tcOut", int'(tcOut), int'(en && expCount == 8'd255));
    @(posedge clk);
    expCount = nextVal(expCount, en, clrN);
    @(negedge clk);
    check(tag, int'(countOut), int'(expCount));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int adv;
    bit haveLast;
    logic [7:0] prev;
    logic en;
    void'($urandom(32'h1C3));
    @(negedge clk);
    // R1: clear with enable high and low
    cycle(1'b1, 1'b0, "R1 clear while enabled");
    cycle(1'b0, 1'b0, "R1 clear while paused");

    // R7: climb from 0 into the loop
    for (int i = 0; i < 63; i++) cycle(1'b1, 1'b1, "R7 entry climb");
    check("R7 reached 63", int'(countOut), 63);

    // R2/R3/R4: one full loop of 193 enabled cycles returns to 63
    adv = 0;
    for (int i = 0; i < LOOP_LEN; i++) begin
      cycle(1'b1, 1'b1, "R2 step");
      adv++;
      if (countOut == 8'd63 && i != LOOP_LEN - 1)
        check("R4 early return to 63", i, LOOP_LEN - 1);
      if (countOut < 8'd63) check("R4 left loop", int'(countOut), 63);
    end
    check("R4 period 193", int'(countOut), 63);

    // R8: pause at nibble boundary 0x4F, then cross
    while (expCount != 8'h4F) cycle(1'b1, 1'b1, "R2 step");
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b1, "R8 paused 0x4F holds");
    cycle(1'b1, 1'b1, "R8 0x4F to 0x50");
    check("R8 upper nibble", int'(countOut[7:4]), 5);

    // R5: pause at an arbitrary value
    while (expCount != 8'd100) cycle(1'b1, 1'b1, "R2 step");
    for (int i = 0; i < 4; i++) cycle(1'b0, 1'b1, "R5 hold at 100");

    // R5/R6/R3: pause at 255, then release
    while (expCount != 8'd255) cycle(1'b1, 1'b1, "R2 step");
    for (int i = 0; i < 5; i++) cycle(1'b0, 1'b1, "R5 hold at 255");
    cycle(1'b1, 1'b1, "R3 wrap 255 to 63");

    // random enables with rare clears: period between wraps
    adv = 0;
    haveLast = 0;
    for (int i = 0; i < 6000; i++) begin
      prev = expCount;
      en = (($urandom % 4) != 0);
      if (($urandom % 500) == 0) begin
        cycle(en, 1'b0, "R1 random clear");
        haveLast = 0;
        adv = 0;
      end else begin
        cycle(en, 1'b1, "R2 random step");
        if (en) adv++;
        if (en && prev == 8'd255) begin
          if (haveLast) check("R4 random period", adv, LOOP_LEN);
          haveLast = 1;
          adv = 0;
        end
      end
    end
    finish_run();
  end
endmodule